// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block performs 32-bit multiplication and division, signed or unsigned, one result bit per clock. It places every result in a private pair of result registers, a high word and a low word, that stay readable on two output ports. A caller raises a one-cycle start strobe together with a 6-bit operation code and two operands. The unit then reports itself busy until the new result is in the pair.

A multiply leaves the full 64-bit product across the pair, with the upper half in the high word. A divide puts the quotient in the low word and the remainder in the high word. Signed work is done on magnitudes, and the signs are applied when the result is written. A divide by zero writes nothing and gives a one-cycle flag instead. A strobe that arrives while the unit is working is dropped, and so is a strobe that carries an unknown code.

Top module: `mdu_unit`

## Requirements
- R1: After reset, hi_o and lo_o are zero and busy_o and div_zero_o are low.
- R2: Code 24 (decimal) multiplies the operands as two's-complement numbers and writes the 64-bit product, with bits 63..32 to hi_o and bits 31..0 to lo_o.
- R3: Code 25 multiplies the operands as unsigned numbers, with the same split of the 64-bit product as R2.
- R4: Code 26 divides as two's-complement numbers with truncation toward zero. The quotient goes to lo_o and the remainder, which has the sign of the dividend, goes to hi_o.
- R5: Code 27 divides as unsigned numbers, with the quotient in lo_o and the remainder in hi_o.
- R6: An accepted multiply or divide holds busy_o high for exactly 33 cycles, counted from the edge after the strobe. hi_o and lo_o keep their values while busy_o is high, and the new result is present when busy_o falls.
- R7: A start strobe that arrives while busy_o is high has no effect. The running operation completes with its own operands and its original timing.
- R8: Code 26 or 27 with a zero divisor leaves hi_o and lo_o unchanged and does not raise busy_o. It raises div_zero_o for exactly the one cycle after the strobe.
- R9: A strobe with any code other than 24 to 27 is ignored. busy_o and div_zero_o stay low and hi_o and lo_o are unchanged.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF gives the wrapped quotient 0x80000000 and a remainder of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| func_i | input | 6 | Operation code (24 to 27) |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| div_zero_o | output | 1 | One-cycle divide-by-zero flag |
| hi_o | output | 32 | High result word |
| lo_o | output | 32 | Low result word |

## Verification
The hardest case to create from the ports is a second strobe that lands in the middle of an iteration. Only an ignored strobe with different operands shows that the running result was not disturbed. The bench starts a multiply and fires a conflicting request a few cycles later. It then checks the product of the first operands and the total busy length of 33 cycles.

The signed corner cases also need specific operand values, because random values almost never produce them. These are the most negative dividend over minus one, mixed-sign remainders, and a divide by zero issued just after a known result. Directed tasks supply each of these operand values.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam logic [5:0] FN_MUL_S = 6'd24;
    localparam logic [5:0] FN_MUL_U = 6'd25;
    localparam logic [5:0] FN_DIV_S = 6'd26;
    localparam logic [5:0] FN_DIV_U = 6'd27;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mdu_state_e;
endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
    parameter int W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_main_o,
    output logic         neg_rem_o
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg      = signed_i & a_i[W-1];
        b_neg      = signed_i & b_i[W-1];
        mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
        neg_main_o = a_neg ^ b_neg;
        neg_rem_o  = a_neg;
    end
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   mcd_i,
    input  logic [W-1:0]   mpr_i,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);
    localparam int W2 = 2 * W;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          active;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  mcd;
        logic [W2-1:0] prod;
    } mul_regs_t;

    mul_regs_t r_d, r_q;
    logic [W:0] sum;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        sum      = {1'b0, r_q.prod[W2-1:W]} + (r_q.prod[0] ? {1'b0, r_q.mcd} : '0);
        if (load_i) begin
            r_d.active = 1'b1;
            r_d.cnt    = CW'(W);
            r_d.mcd    = mcd_i;
            r_d.prod   = {{W{1'b0}}, mpr_i};
        end else if (r_q.active) begin
            r_d.prod = {sum, r_q.prod[W-1:1]};
            r_d.cnt  = r_q.cnt - CW'(1);
            if (r_q.cnt == CW'(1)) begin
                r_d.active = 1'b0;
                r_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign prod_o = r_q.prod;

    // R7
    mul_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !r_q.active);

    // R6
    mul_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          active;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  dvs;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shifted  = {r_q.rem, r_q.quo[W-1]};
        trial    = shifted - {1'b0, r_q.dvs};
        if (load_i) begin
            r_d.active = 1'b1;
            r_d.cnt    = CW'(W);
            r_d.dvs    = dvs_i;
            r_d.quo    = dvd_i;
            r_d.rem    = '0;
        end else if (r_q.active) begin
            if (!trial[W]) begin
                r_d.rem = trial[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b1};
            end else begin
                r_d.rem = shifted[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - CW'(1);
            if (r_q.cnt == CW'(1)) begin
                r_d.active = 1'b0;
                r_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign quo_o  = r_q.quo;
    assign rem_o  = r_q.rem;

    // R7
    div_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !r_q.active);

    // R5
    div_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.active |-> (r_q.rem < r_q.dvs));

    // R8
    div_nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (dvs_i != '0));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [5:0]   func_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         div_zero_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    import mdu_pkg::*;

    localparam int W2 = 2 * W;

    typedef struct packed {
        mdu_state_e   state;
        logic         is_div;
        logic         neg_main;
        logic         neg_rem;
        logic         dz;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic          is_mul, is_div, is_signed, known, accept, dz_hit;
    logic          launch_mul, launch_div;
    logic [W-1:0]  mag_a, mag_b;
    logic          neg_main, neg_rem;
    logic          mul_done, div_done;
    logic [W2-1:0] prod;
    logic [W-1:0]  quo, rem;
    logic [W2-1:0] prod_fix;

    always_comb begin
        is_mul     = (func_i == FN_MUL_S) || (func_i == FN_MUL_U);
        is_div     = (func_i == FN_DIV_S) || (func_i == FN_DIV_U);
        is_signed  = (func_i == FN_MUL_S) || (func_i == FN_DIV_S);
        known      = is_mul || is_div;
        accept     = start_i && (r_q.state == ST_IDLE) && known;
        dz_hit     = accept && is_div && (opb_i == '0);
        launch_mul = accept && is_mul;
        launch_div = accept && is_div && (opb_i != '0);
    end

    mdu_operand_prep #(.W(W)) u_prep (
        .signed_i   (is_signed),
        .a_i        (opa_i),
        .b_i        (opb_i),
        .mag_a_o    (mag_a),
        .mag_b_o    (mag_b),
        .neg_main_o (neg_main),
        .neg_rem_o  (neg_rem)
    );

    mdu_mul_core #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (launch_mul),
        .mcd_i  (mag_a),
        .mpr_i  (mag_b),
        .done_o (mul_done),
        .prod_o (prod)
    );

    mdu_div_core #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (launch_div),
        .dvd_i  (mag_a),
        .dvs_i  (mag_b),
        .done_o (div_done),
        .quo_o  (quo),
        .rem_o  (rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.dz   = 1'b0;
        prod_fix = r_q.neg_main ? (~prod + 1'b1) : prod;
        case (r_q.state)
            ST_IDLE: begin
                if (dz_hit) begin
                    r_d.dz = 1'b1;
                end else if (launch_mul || launch_div) begin
                    r_d.state    = ST_RUN;
                    r_d.is_div   = launch_div;
                    r_d.neg_main = neg_main;
                    r_d.neg_rem  = neg_rem;
                end
            end
            ST_RUN: begin
                if (r_q.is_div && div_done) begin
                    r_d.lo    = r_q.neg_main ? (~quo + 1'b1) : quo;
                    r_d.hi    = r_q.neg_rem ? (~rem + 1'b1) : rem;
                    r_d.state = ST_IDLE;
                end else if (!r_q.is_div && mul_done) begin
                    r_d.hi    = prod_fix[W2-1:W];
                    r_d.lo    = prod_fix[W-1:0];
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o     = (r_q.state == ST_RUN);
    assign div_zero_o = r_q.dz;
    assign hi_o       = r_q.hi;
    assign lo_o       = r_q.lo;

    // R6
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(hi_o) && $stable(lo_o))));

    // R8
    dz_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |=> !div_zero_o);

    // R8
    dz_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (!busy_o && $stable(hi_o) && $stable(lo_o)));

    // R9
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !known && !busy_o) |=> (!busy_o && !div_zero_o));

    // R6
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_done && div_done));
endmodule

// File: tb/mdu_unit_bench.sv
`timescale 1ns/1ps
module mdu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  func_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o, div_zero_o;
    logic [31:0] hi_o, lo_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mdu_unit u_mdu_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .func_i     (func_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .busy_o     (busy_o),
        .div_zero_o (div_zero_o),
        .hi_o       (hi_o),
        .lo_o       (lo_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [5:0] f,
                                          input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] res;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        res = '0;
        case (f)
            6'd24: res = 64'(sa * sb);
            6'd25: res = {32'b0, a} * {32'b0, b};
            6'd26: begin
                q = sa / sb;
                r = sa % sb;
                res = {r[31:0], q[31:0]};
            end
            6'd27: res = {a % b, a / b};
            default: res = '0;
        endcase
        return res;
    endfunction

    task automatic run_op(input logic [5:0] f, input logic [31:0] a,
                          input logic [31:0] b, output int cycles);
        @(negedge clk);
        start_i = 1'b1; func_i = f; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 0;
        while (busy_o) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic op_check(input string req, input logic [5:0] f,
                            input logic [31:0] a, input logic [31:0] b);
        int cyc;
        run_op(f, a, b, cyc);
        chk(req, "result hi:lo", {hi_o, lo_o}, model(f, a, b));
    endtask

    task automatic t_reset();
        chk("R1", "reset hi:lo", {hi_o, lo_o}, 64'h0);
        chk("R1", "reset busy/dz", {62'b0, busy_o, div_zero_o}, 64'h0);
    endtask

    task automatic t_mul_signed();
        op_check("R2", 6'd24, 32'd7, 32'hFFFFFFFD);
        op_check("R2", 6'd24, 32'h80000000, 32'h80000000);
        op_check("R2", 6'd24, 32'hFFFFFFFF, 32'h7FFFFFFF);
        op_check("R2", 6'd24, 32'h12345678, 32'h0);
    endtask

    task automatic t_mul_unsigned();
        op_check("R3", 6'd25, 32'hFFFFFFFF, 32'hFFFFFFFF);
        op_check("R3", 6'd25, 32'h80000000, 32'd2);
        op_check("R3", 6'd25, 32'd12345, 32'd6789);
    endtask

    task automatic t_div_signed();
        op_check("R4", 6'd26, 32'hFFFFFFF9, 32'd2);
        op_check("R4", 6'd26, 32'd7, 32'hFFFFFFFE);
        op_check("R4", 6'd26, 32'hFFFFFFF9, 32'hFFFFFFFE);
        op_check("R4", 6'd26, 32'd3, 32'd100);
    endtask

    task automatic t_div_unsigned();
        op_check("R5", 6'd27, 32'hFFFFFFFF, 32'd10);
        op_check("R5", 6'd27, 32'd5, 32'hFFFFFFFF);
        op_check("R5", 6'd27, 32'h80000000, 32'h80000000);
    endtask

    task automatic t_latency();
        int cyc;
        logic [31:0] h0, l0;
        op_check("R6", 6'd25, 32'd11, 32'd13);
        h0 = hi_o; l0 = lo_o;
        @(negedge clk);
        start_i = 1'b1; func_i = 6'd27; opa_i = 32'd1000; opb_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (busy_o) begin
            if ({hi_o, lo_o} !== {h0, l0})
                chk("R6", "result changed while busy", {hi_o, lo_o}, {h0, l0});
            cyc++;
            @(negedge clk);
        end
        chk("R6", "busy length", 64'(cyc), 64'd33);
        chk("R6", "result at busy fall", {hi_o, lo_o}, {32'd6, 32'd142});
    endtask

    task automatic t_ignore_start();
        int cyc;
        @(negedge clk);
        start_i = 1'b1; func_i = 6'd24; opa_i = 32'd3; opb_i = 32'd5;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        for (int k = 0; k < 8; k++) begin
            if (busy_o) cyc++;
            if (k == 4) begin
                start_i = 1'b1; func_i = 6'd27; opa_i = 32'd99; opb_i = 32'd4;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        while (busy_o) begin
            cyc++;
            @(negedge clk);
        end
        chk("R7", "busy length with mid strobe", 64'(cyc), 64'd33);
        chk("R7", "first operation result", {hi_o, lo_o}, 64'd15);
        repeat (3) @(negedge clk);
        chk("R7", "no restart after completion", {63'b0, busy_o}, 64'd0);
    endtask

    task automatic t_div_zero();
        int cyc;
        op_check("R8", 6'd24, 32'hDEADBEEF, 32'h00000321);
        @(negedge clk);
        start_i = 1'b1; func_i = 6'd26; opa_i = 32'd50; opb_i = 32'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8", "flag after strobe", {63'b0, div_zero_o}, 64'd1);
        chk("R8", "no busy", {63'b0, busy_o}, 64'd0);
        @(negedge clk);
        chk("R8", "flag one cycle", {63'b0, div_zero_o}, 64'd0);
        chk("R8", "hi:lo kept", {hi_o, lo_o}, model(6'd24, 32'hDEADBEEF, 32'h00000321));
        run_op(6'd27, 32'd9, 32'd0, cyc);
        chk("R8", "unsigned zero no busy", 64'(cyc), 64'd0);
        chk("R8", "unsigned zero kept", {hi_o, lo_o}, model(6'd24, 32'hDEADBEEF, 32'h00000321));
    endtask

    task automatic t_bad_code();
        logic [63:0] prev;
        prev = {hi_o, lo_o};
        @(negedge clk);
        start_i = 1'b1; func_i = 6'd32; opa_i = 32'd4; opb_i = 32'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy/dz for bad code", {62'b0, busy_o, div_zero_o}, 64'd0);
        func_i = 6'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy/dz for code 0", {62'b0, busy_o, div_zero_o}, 64'd0);
        chk("R9", "hi:lo unchanged", {hi_o, lo_o}, prev);
    endtask

    task automatic t_overflow_div();
        op_check("R10", 6'd26, 32'h80000000, 32'hFFFFFFFF);
        chk("R10", "wrapped quotient", {hi_o, lo_o}, {32'h0, 32'h80000000});
    endtask

    task automatic t_random();
        logic [31:0] a, b;
        logic [5:0] f;
        for (int i = 0; i < 24; i++) begin
            a = $urandom();
            b = $urandom();
            if ((i % 3) == 0) b = b >> (i % 29);
            f = 6'(24 + (i % 4));
            if (b == 0) b = 32'd1;
            case (f)
                6'd24: op_check("R2", f, a, b);
                6'd25: op_check("R3", f, a, b);
                6'd26: op_check("R4", f, a, b);
                default: op_check("R5", f, a, b);
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul_signed();
        t_mul_unsigned();
        t_div_signed();
        t_div_unsigned();
        t_latency();
        t_ignore_start();
        t_div_zero();
        t_bad_code();
        t_overflow_div();
        t_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule